// File: doc/BRIEF.md
# Balanced-Tree Texture Tile Index Walker

This block turns the coordinates of a 4×4 texel tile into the address of the storage block that holds the tile's data. A texture's tiles are located through a balanced search tree. Every tree node is a fixed 256-byte block, and every level of the tree has the same height. The walker first forms a space-filling-curve key by interleaving the bits of the tile coordinates. It then reads one node per level from a simple request/response memory port, beginning at the texture's root pointer. All key slots of a fetched node are compared against the search key at once. The walker keeps the child whose key interval holds the key.

The caller supplies the root pointer and the tree depth with each lookup, because the depth is a property of the texture and is not kept in the nodes. After that number of levels, the chosen pointer names a leaf block. The result then gives the leaf pointer, the leaf's compressed marker and the distance of the key from the leaf entry's first key. If no interval holds the key at any level, the walker reports not-found, and the caller uses the texture's default colour. Only one lookup is in flight at a time.

Top module: `btree_index_search`

## Requirements
- R1: The search key has 20 bits. Bit 2i of the key is bit i of `req_tile_x`, and bit 2i+1 is bit i of `req_tile_y`, for i from 0 to 9.
- R2: A node is 2048 bits. Slot i (0..44) occupies bits [45i+44:45i]. Within a slot, the key is in bits 19:0, the child pointer in bits 43:20 and the compressed marker in bit 44. The node's exclusive upper key bound sits in bits [2044:2025].
- R3: A node's slots are live only up to the first slot whose key is 20'hFFFFF. That slot and every slot after it are ignored, whatever they contain.
- R4: At each level the walker selects the last live slot whose key is less than or equal to the search key. The level misses when no live slot qualifies or when the search key is at or above the node's upper bound. A miss ends the lookup as not-found with no further fetch.
- R5: The first fetch uses the root pointer. Each later fetch uses the child pointer selected at the level above. A lookup that hits at every level makes exactly `req_depth` fetches.
- R6: When the deepest level hits, the result reports found. It gives that slot's pointer as the leaf pointer and that slot's marker as the compressed flag. The offset is the search key minus that slot's key. Markers seen at the levels above have no effect. A not-found result gives zero pointer, flag and offset.
- R7: A request with `req_depth` of 0 is answered as not-found in the cycle after acceptance, with no fetch.
- R8: `mem_req_valid` is a one-cycle pulse. It is raised in the cycle after acceptance, and again in the cycle after each hitting non-final response. `res_valid` is a one-cycle pulse in the cycle after the deciding response. `busy` is high from the cycle after acceptance through the `res_valid` cycle. `req_valid` is ignored while `busy` is high.
- R9: During and right after reset, `busy`, `mem_req_valid` and `res_valid` are low.
- R10: The result outputs keep their values from one result to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a lookup (accepted only when not busy) |
| req_tile_x | input | 10 | Tile column |
| req_tile_y | input | 10 | Tile row |
| req_root_ptr | input | 24 | Block pointer of the tree root |
| req_depth | input | 3 | Number of index levels in this texture's tree |
| busy | output | 1 | Lookup in progress |
| mem_req_valid | output | 1 | Node fetch request pulse |
| mem_req_ptr | output | 24 | Block pointer of the node to fetch |
| mem_rsp_valid | input | 1 | Node data present |
| mem_rsp_data | input | 2048 | Fetched node contents |
| res_valid | output | 1 | Result pulse |
| res_found | output | 1 | Key covered by the tree |
| res_compressed | output | 1 | Leaf block holds compressed tiles |
| res_leaf_ptr | output | 24 | Block pointer of the leaf |
| res_offset | output | 20 | Search key minus leaf entry key |

## Verification
The hardest cases to reach from the ports are the ones where the lookup ends in the middle of the tree. One is a key that the root passes down but that falls into a gap below the first key of a second-level node. The other is a node whose live run is ended by a pad slot, followed by a slot that would otherwise match. The stimulus builds a two-level tree with a gap between the key ranges of two children, and a node with a planted slot after the pad. It then picks tile coordinates whose interleaved keys land in the gap, on slot edges, on the last of 45 slots and just past an upper bound. Response latency varies between lookups, and a second request is driven while a lookup is busy to show that it is dropped.

// File: rtl/btree_idx_pkg.sv
package btree_idx_pkg;

    localparam int KEY_W      = 20;
    localparam int PTR_W      = 24;
    localparam int COORD_W    = KEY_W / 2;
    localparam int SLOTS      = 45;
    localparam int ENTRY_W    = KEY_W + PTR_W + 1;
    localparam int NODE_BYTES = 256;
    localparam int NODE_W     = NODE_BYTES * 8;
    localparam int BOUND_LSB  = SLOTS * ENTRY_W;
    localparam int DEPTH_W    = 3;

    typedef logic [KEY_W-1:0] key_t;
    typedef logic [PTR_W-1:0] ptr_t;

    localparam key_t PAD_KEY = '1;

    // slot layout: key in the low bits, pointer above, marker on top
    typedef struct packed {
        logic comp;
        ptr_t ptr;
        key_t key;
    } slot_t;

    typedef struct packed {
        logic found;
        logic comp;
        ptr_t ptr;
        key_t offset;
    } lookup_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } walk_state_t;

    function automatic key_t node_bound(input logic [NODE_W-1:0] node);
        return node[BOUND_LSB +: KEY_W];
    endfunction

endpackage

// File: rtl/btree_morton.sv
module btree_morton #(
    parameter int CW = btree_idx_pkg::COORD_W
) (
    input  logic [CW-1:0]   x,
    input  logic [CW-1:0]   y,
    output logic [2*CW-1:0] key
);
    for (genvar b = 0; b < CW; b++) begin : g_bit
        assign key[2*b]   = x[b];
        assign key[2*b+1] = y[b];
    end
endmodule

// File: rtl/btree_node_search.sv
module btree_node_search
    import btree_idx_pkg::*;
(
    input  logic [NODE_W-1:0] node,
    input  key_t              skey,
    output logic              hit,
    output slot_t             pick
);
    slot_t             slot_e [SLOTS];
    logic [SLOTS-1:0]  live;
    logic [SLOTS-1:0]  reach;
    logic [SLOTS-1:0]  last_reach;
    key_t              bound;
    logic              unused_tail;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot_e[i] = slot_t'(node[i*ENTRY_W +: ENTRY_W]);
    end

    assign bound       = node_bound(node);
    assign unused_tail = ^node[NODE_W-1:BOUND_LSB+KEY_W];

    // live run ends at the first pad key; reach marks live keys not above skey
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
            run      = run & (slot_e[i].key != PAD_KEY);
            live[i]  = run;
            reach[i] = run & (slot_e[i].key <= skey);
        end
    end

    // sorted keys make reach a low-side run; its top bit is the chosen child
    assign last_reach = reach & ~(reach >> 1);

    always_comb begin
        pick = '0;
        for (int i = 0; i < SLOTS; i++) begin
            pick = pick | (last_reach[i] ? slot_e[i] : slot_t'('0));
        end
    end

    assign hit = reach[0] & (skey < bound) & live[0];
endmodule

// File: rtl/btree_index_search.sv
module btree_index_search
    import btree_idx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [COORD_W-1:0]   req_tile_x,
    input  logic [COORD_W-1:0]   req_tile_y,
    input  logic [PTR_W-1:0]     req_root_ptr,
    input  logic [DEPTH_W-1:0]   req_depth,
    output logic                 busy,
    output logic                 mem_req_valid,
    output logic [PTR_W-1:0]     mem_req_ptr,
    input  logic                 mem_rsp_valid,
    input  logic [NODE_W-1:0]    mem_rsp_data,
    output logic                 res_valid,
    output logic                 res_found,
    output logic                 res_compressed,
    output logic [PTR_W-1:0]     res_leaf_ptr,
    output logic [KEY_W-1:0]     res_offset
);
    walk_state_t          state;
    key_t                 key_q;
    key_t                 key_in;
    ptr_t                 ptr_q;
    logic [DEPTH_W-1:0]   depth_q;
    logic [DEPTH_W-1:0]   level_q;
    lookup_t              res_q;
    logic                 node_hit;
    slot_t                node_pick;
    logic                 rsp_now;

    btree_morton #(.CW(COORD_W)) u_morton (
        .x   (req_tile_x),
        .y   (req_tile_y),
        .key (key_in)
    );

    btree_node_search u_search (
        .node (mem_rsp_data),
        .skey (key_q),
        .hit  (node_hit),
        .pick (node_pick)
    );

    assign rsp_now = (state == ST_WAIT) && mem_rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            key_q   <= '0;
            ptr_q   <= '0;
            depth_q <= '0;
            level_q <= '0;
            res_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        key_q   <= key_in;
                        ptr_q   <= req_root_ptr;
                        depth_q <= req_depth;
                        level_q <= DEPTH_W'(1);
                        if (req_depth == '0) begin
                            res_q <= '0;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!node_hit) begin
                            res_q <= '0;
                            state <= ST_DONE;
                        end else if (level_q == depth_q) begin
                            res_q.found  <= 1'b1;
                            res_q.comp   <= node_pick.comp;
                            res_q.ptr    <= node_pick.ptr;
                            res_q.offset <= key_q - node_pick.key;
                            state        <= ST_DONE;
                        end else begin
                            ptr_q   <= node_pick.ptr;
                            level_q <= level_q + DEPTH_W'(1);
                            state   <= ST_FETCH;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy           = (state != ST_IDLE);
    assign mem_req_valid  = (state == ST_FETCH);
    assign mem_req_ptr    = ptr_q;
    assign res_valid      = (state == ST_DONE);
    assign res_found      = res_q.found;
    assign res_compressed = res_q.comp;
    assign res_leaf_ptr   = res_q.ptr;
    assign res_offset     = res_q.offset;

    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    assert_res_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_level_range_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (level_q >= DEPTH_W'(1) && level_q <= depth_q));

    assert_descend_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_now && node_hit && level_q != depth_q)
        |=> (mem_req_valid && mem_req_ptr == $past(node_pick.ptr)));

    assert_miss_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_now && !node_hit) |=> (res_valid && !res_found && !mem_req_valid));

    assert_zero_depth_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_depth == '0) |=> (res_valid && !res_found));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_found) && $stable(res_leaf_ptr)
                        && $stable(res_offset) && $stable(res_compressed)));
endmodule

// File: tb/btree_index_search_tb.sv
module btree_index_search_tb;
    localparam int NW = 2048;
    localparam int EW = 45;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [9:0]       req_tile_x = '0;
    logic [9:0]       req_tile_y = '0;
    logic [23:0]      req_root_ptr = '0;
    logic [2:0]       req_depth = '0;
    logic             busy;
    logic             mem_req_valid;
    logic [23:0]      mem_req_ptr;
    logic             mem_rsp_valid = 1'b0;
    logic [NW-1:0]    mem_rsp_data = '0;
    logic             res_valid;
    logic             res_found;
    logic             res_compressed;
    logic [23:0]      res_leaf_ptr;
    logic [19:0]      res_offset;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [NW-1:0] nodes [16];
    logic [19:0]   sk [45];
    logic [23:0]   sp [45];
    logic          sf [45];

    always #10 clk = ~clk;

    btree_index_search u_dut (
        .clk, .rst, .req_valid, .req_tile_x, .req_tile_y, .req_root_ptr,
        .req_depth, .busy, .mem_req_valid, .mem_req_ptr, .mem_rsp_valid,
        .mem_rsp_data, .res_valid, .res_found, .res_compressed,
        .res_leaf_ptr, .res_offset
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] ref_key(input int x, input int y);
        int acc = 0;
        for (int b = 0; b < 10; b++) begin
            acc += ((x >> b) & 1) * (1 << (2*b));
            acc += ((y >> b) & 1) * (1 << (2*b + 1));
        end
        return acc[19:0];
    endfunction

    task automatic build(input int slot, input int n, input logic [19:0] bound);
        logic [NW-1:0] nd = '0;
        for (int i = 0; i < 45; i++) begin
            if (i < n) nd[i*EW +: EW] = {sf[i], sp[i], sk[i]};
            else       nd[i*EW +: EW] = {1'b0, 24'h0, 20'hFFFFF};
        end
        nd[2025 +: 20] = bound;
        nodes[slot] = nd;
    endtask

    task automatic ref_search(input logic [NW-1:0] nd, input logic [19:0] k,
                              output bit hit, output logic [19:0] ek,
                              output logic [23:0] ep, output logic ef);
        hit = 0; ek = '0; ep = '0; ef = 0;
        for (int i = 0; i < 45; i++) begin
            logic [EW-1:0] e = nd[i*EW +: EW];
            if (e[19:0] == 20'hFFFFF) break;
            if (e[19:0] <= k) begin
                hit = 1; ek = e[19:0]; ep = e[43:20]; ef = e[44];
            end
        end
        if (k >= nd[2025 +: 20]) hit = 0;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lookup(input int x, input int y, input logic [23:0] root,
                          input int depth, input int lat, input bit poke,
                          input string tag);
        logic [19:0] k = ref_key(x, y);
        logic [23:0] exp_ptr = root;
        int lvl = 1;
        bit hit; logic [19:0] ek; logic [23:0] ep; logic ef;
        logic [23:0] keep_ptr; logic [19:0] keep_ofs; logic keep_found;
        req_tile_x = x[9:0]; req_tile_y = y[9:0];
        req_root_ptr = root; req_depth = depth[2:0]; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        chk("R8", {tag, " busy after accept"}, busy, 1);
        if (depth == 0) begin
            chk("R7", {tag, " res_valid"}, res_valid, 1);
            chk("R7", {tag, " found"}, res_found, 0);
            chk("R7", {tag, " no fetch"}, mem_req_valid, 0);
        end else begin
            forever begin
                chk("R5", {tag, " fetch pulse"}, mem_req_valid, 1);
                chk("R5", {tag, " fetch ptr"}, mem_req_ptr, exp_ptr);
                chk("R8", {tag, " no result yet"}, res_valid, 0);
                if (poke && lvl == 1) begin
                    req_tile_x = 10'h3FF; req_tile_y = 10'h2AA;
                    req_root_ptr = 24'h0A0005; req_depth = 3'd1; req_valid = 1'b1;
                end
                tick();
                req_valid = 1'b0;
                for (int c = 0; c < lat; c++) begin
                    chk("R8", {tag, " idle wait"}, {busy, mem_req_valid, res_valid}, 3'b100);
                    tick();
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_data = nodes[exp_ptr[3:0]];
                ref_search(nodes[exp_ptr[3:0]], k, hit, ek, ep, ef);
                tick();
                mem_rsp_valid = 1'b0;
                mem_rsp_data = '0;
                if (!hit || lvl == depth) begin
                    chk("R8", {tag, " result pulse"}, res_valid, 1);
                    chk("R8", {tag, " busy at result"}, busy, 1);
                    chk("R5", {tag, " no extra fetch"}, mem_req_valid, 0);
                    chk("R4", {tag, " found"}, res_found, hit);
                    chk("R6", {tag, " leaf ptr R2"}, res_leaf_ptr, hit ? ep : 24'h0);
                    chk("R6", {tag, " compressed"}, res_compressed, hit ? ef : 1'b0);
                    chk("R6", {tag, " offset R1"}, res_offset, hit ? (k - ek) : 20'h0);
                    break;
                end
                exp_ptr = ep;
                lvl++;
            end
        end
        keep_ptr = res_leaf_ptr; keep_ofs = res_offset; keep_found = res_found;
        tick();
        chk("R8", {tag, " busy drops"}, {busy, res_valid}, 2'b00);
        tick();
        chk("R10", {tag, " held"}, {keep_found, keep_ptr, keep_ofs},
            {res_found, res_leaf_ptr, res_offset});
    endtask

    task automatic expect_result(input string req, input string what,
                                 input logic found, input logic [23:0] ptr,
                                 input logic comp, input logic [19:0] ofs);
        chk(req, {what, " found"}, res_found, found);
        chk(req, {what, " ptr"}, res_leaf_ptr, ptr);
        chk(req, {what, " comp"}, res_compressed, comp);
        chk(req, {what, " offset"}, res_offset, ofs);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // slot 1: root of a two-level tree; internal markers all set
        sk[0] = 20'h00000; sp[0] = 24'h0A0002; sf[0] = 1;
        sk[1] = 20'h00400; sp[1] = 24'h0A0003; sf[1] = 1;
        sk[2] = 20'h01000; sp[2] = 24'h0A0004; sf[2] = 1;
        build(1, 3, 20'h40000);
        // slot 2: three leaves
        sk[0] = 20'h00000; sp[0] = 24'h100000; sf[0] = 0;
        sk[1] = 20'h00010; sp[1] = 24'h100001; sf[1] = 1;
        sk[2] = 20'h00020; sp[2] = 24'h100002; sf[2] = 0;
        build(2, 3, 20'h00400);
        // slot 3: completely full node
        for (int i = 0; i < 45; i++) begin
            sk[i] = 20'h00400 + 20'(i * 8); sp[i] = 24'h200000 + 24'(i); sf[i] = i[0];
        end
        build(3, 45, 20'h01000);
        // slot 4: starts above the root's interval start (gap)
        sk[0] = 20'h01100; sp[0] = 24'h300000; sf[0] = 1;
        sk[1] = 20'h01200; sp[1] = 24'h300001; sf[1] = 0;
        build(4, 2, 20'h40000);
        // slot 5: empty node
        build(5, 0, 20'hFFFFF);
        // slot 6: single far key
        sk[0] = 20'h55555; sp[0] = 24'hABCDEF; sf[0] = 1;
        build(6, 1, 20'h55556);
        // slot 7: live run ended by pad, then a planted slot
        sk[0] = 20'h00000; sp[0] = 24'h400000; sf[0] = 0;
        sk[1] = 20'h00008; sp[1] = 24'h400001; sf[1] = 1;
        build(7, 2, 20'h00400);
        nodes[7][3*EW +: EW] = {1'b0, 24'h000BAD, 20'h00010};

        repeat (3) @(negedge clk);
        chk("R9", "reset outputs", {busy, mem_req_valid, res_valid}, 3'b000);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "after reset", {busy, mem_req_valid, res_valid}, 3'b000);

        lookup(0, 0, 24'h0A0001, 2, 0, 0, "key0");
        expect_result("R6", "key0", 1, 24'h100000, 0, 20'h0);
        lookup(5, 3, 24'h0A0001, 2, 2, 0, "key1B");
        expect_result("R1", "key1B", 1, 24'h100001, 1, 20'h0000B);
        lookup(63, 63, 24'h0A0001, 2, 1, 0, "lastslot");
        expect_result("R4", "lastslot", 1, 24'h20002C, 0, 20'h00A9F);
        lookup(76, 0, 24'h0A0001, 2, 3, 0, "gap");
        expect_result("R4", "gap miss level2", 0, 24'h0, 0, 20'h0);
        lookup(512, 0, 24'h0A0001, 2, 0, 0, "overbound");
        expect_result("R4", "root bound miss", 0, 24'h0, 0, 20'h0);
        lookup(9, 9, 24'h0A0001, 0, 0, 0, "depth0");
        expect_result("R7", "depth0", 0, 24'h0, 0, 20'h0);
        lookup(3, 3, 24'h0A0005, 1, 1, 0, "empty");
        expect_result("R3", "empty node", 0, 24'h0, 0, 20'h0);
        lookup(1023, 0, 24'h0A0006, 1, 0, 0, "far");
        expect_result("R1", "far key", 1, 24'hABCDEF, 1, 20'h0);
        lookup(1023, 1, 24'h0A0006, 1, 0, 0, "pastfar");
        expect_result("R4", "just past bound", 0, 24'h0, 0, 20'h0);
        lookup(0, 4, 24'h0A0002, 1, 1, 0, "edge20");
        expect_result("R6", "exact slot key", 1, 24'h100002, 0, 20'h0);
        lookup(31, 31, 24'h0A0002, 1, 0, 0, "top3FF");
        expect_result("R6", "interval top", 1, 24'h100002, 0, 20'h003DF);
        lookup(5, 3, 24'h0A0007, 1, 2, 0, "padstop");
        expect_result("R3", "slot after pad ignored", 1, 24'h400001, 1, 20'h00013);
        lookup(5, 3, 24'h0A0001, 2, 1, 1, "poke");
        expect_result("R8", "request while busy ignored", 1, 24'h100001, 1, 20'h0000B);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule